// File: doc/BRIEF.md
# Stereo Two-Section Biquad Equalizer

This block shapes the tone of a stereo audio stream ahead of a digital-to-analog converter. Each channel runs a fourth-order recursive filter, built as two second-order sections in series. Every section has a numerator written as b0 + 2·b1·z⁻¹ + b2·z⁻² and a denominator written as 32768 − 2·a1·z⁻¹ − a2·z⁻². All coefficients are signed 16-bit integers. After reset both channels hold a bass-boost set, so the path works without any programming.

Samples enter as signed 16-bit words, one pair per `in_valid` pulse. Filtered samples leave two clock cycles later on `out_valid`. A single enable input switches both channels between the filtered result and an unaltered copy of the input. A write port (`cfg_we`, `cfg_addr`, `cfg_wdata`) loads new coefficients into either channel. A coefficient only takes part at a sample boundary, so no sample is ever computed from a mix of old and new sets.

Top module: `eq_stereo`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid`, `out_left` and `out_right` are 0. Every channel's coefficient slots reset as follows: slots 0 and 5 = 27618, slots 1 and 6 = −27033, slots 2 and 7 = 26461, slots 3 and 8 = 32130, slots 4 and 9 = −31505.
- R2: A write with `cfg_we` high selects the channel with `cfg_addr[4]` (0 = left, 1 = right) and the slot with `cfg_addr[3:0]`. Slots 0..4 hold b0, b1, b2, a1, a2 of the first section. Slots 5..9 hold the same five coefficients of the second section. Writes to slots 10..15 are dropped.
- R3: While enabled, each section computes y = floor((b0·x + 2·b1·x1 + b2·x2 + 2·a1·y1 + a2·y2) / 32768). Here x1 and x2 are the section's two previous inputs and y1 and y2 are its two previous outputs.
- R4: Each section's result is clamped to the range −32768..32767. The clamped value is what feeds the next section, the section's own history and the channel output.
- R5: `out_valid` rises exactly two cycles after `in_valid` and lasts one cycle per input sample.
- R6: With `eq_en` low at the input sample, the outputs two cycles later equal that sample's inputs exactly.
- R7: The first sample taken with `eq_en` high after a sample taken with it low clears the history of both sections to zero before that sample is computed.
- R8: A coefficient write in the same cycle as `in_valid` does not affect that sample. It applies from the next sample on.
- R9: The left and right channels have separate coefficients and history. A write to one channel never changes the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eq_en | input | 1 | Filter enable, sampled with each input sample |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 16 | Left input sample, signed |
| in_right | input | 16 | Right input sample, signed |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 5 | Channel select (bit 4) and coefficient slot (bits 3:0) |
| cfg_wdata | input | 16 | Coefficient value, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 16 | Left output sample, signed |
| out_right | output | 16 | Right output sample, signed |

## Verification
The assertions check the timing of the sample strobe on every cycle: a fixed latency of two and no output without a matching input. They also check the reset state of the outputs and that the bypass copies both channels bit for bit. The arithmetic needs test cases. These include gain vectors with hand-computed floor rounding and a reference recursion run on the reset coefficients at full amplitude. Further cases cover a clamp that would otherwise wrap, a write in the same cycle as a sample, a write to a dropped slot, and a re-enable after accumulated history. Only these cases can show R2, R3, R4, R7, R8 and R9.

// File: rtl/eq_pkg.sv
package eq_pkg;

  localparam int SECT_COEFS = 5;

  typedef enum int {
    CF_B0 = 0,
    CF_B1 = 1,
    CF_B2 = 2,
    CF_A1 = 3,
    CF_A2 = 4
  } coef_slot_e;

  // Power-up coefficient for a flat slot number; every section shares one set.
  function automatic int coef_default(int idx);
    coef_slot_e slot;
    slot = coef_slot_e'(idx % SECT_COEFS);
    case (slot)
      CF_B0:   return 27618;
      CF_B1:   return -27033;
      CF_B2:   return 26461;
      CF_A1:   return 32130;
      CF_A2:   return -31505;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/eq_coef_bank.sv
module eq_coef_bank #(
  parameter int COEF_W   = 16,
  parameter int NUM_COEF = 10,
  parameter int IDX_W    = 4,
  parameter int LIVE_N   = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [COEF_W-1:0]                wr_data,
  input  logic                             commit,
  output logic [NUM_COEF-1:0][COEF_W-1:0]  view
);

  // Staging copy written by the configuration port.
  logic [NUM_COEF-1:0][COEF_W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_COEF; i++) begin
        shadow[i] <= COEF_W'(eq_pkg::coef_default(i));
      end
    end else if (wr_en && (wr_idx < IDX_W'(NUM_COEF))) begin
      shadow[wr_idx] <= wr_data;
    end
  end

  // Slots read in the commit cycle itself see the staging copy directly.
  // Slots read later in the pipeline get a held copy taken at commit.
  for (genvar i = 0; i < NUM_COEF; i++) begin : g_slot
    if (i < LIVE_N) begin : g_live
      assign view[i] = shadow[i];
    end else begin : g_held
      logic [COEF_W-1:0] held;
      always_ff @(posedge clk) begin
        if (rst) begin
          held <= COEF_W'(eq_pkg::coef_default(i));
        end else if (commit) begin
          held <= shadow[i];
        end
      end
      assign view[i] = held;
    end
  end

endmodule

// File: rtl/eq_section.sv
module eq_section #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          step,
  input  logic                                          run,
  input  logic                                          clear,
  input  logic signed [DATA_W-1:0]                      x_in,
  input  logic [eq_pkg::SECT_COEFS-1:0][COEF_W-1:0]     coef,
  output logic signed [DATA_W-1:0]                      y_out
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int FRAC   = COEF_W - 1;
  localparam logic signed [ACC_W-1:0] Y_HI = ACC_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] Y_LO = -Y_HI - ACC_W'(1);

  logic signed [DATA_W-1:0] x1_q, x2_q, y1_q, y2_q;
  logic signed [DATA_W-1:0] x1, x2, y1, y2;
  logic signed [COEF_W-1:0] b0, b1, b2, a1, a2;
  logic signed [PROD_W-1:0] p0, p1, p2, p3, p4;
  logic signed [ACC_W-1:0]  acc, scaled;

  always_comb begin
    x1 = clear ? '0 : x1_q;
    x2 = clear ? '0 : x2_q;
    y1 = clear ? '0 : y1_q;
    y2 = clear ? '0 : y2_q;
    b0 = $signed(coef[eq_pkg::CF_B0]);
    b1 = $signed(coef[eq_pkg::CF_B1]);
    b2 = $signed(coef[eq_pkg::CF_B2]);
    a1 = $signed(coef[eq_pkg::CF_A1]);
    a2 = $signed(coef[eq_pkg::CF_A2]);
    p0 = b0 * x_in;
    p1 = b1 * x1;
    p2 = b2 * x2;
    p3 = a1 * y1;
    p4 = a2 * y2;
    acc = ACC_W'(p0) + (ACC_W'(p1) <<< 1) + ACC_W'(p2)
        + (ACC_W'(p3) <<< 1) + ACC_W'(p4);
    scaled = acc >>> FRAC;
    if (scaled > Y_HI) begin
      y_out = Y_HI[DATA_W-1:0];
    end else if (scaled < Y_LO) begin
      y_out = Y_LO[DATA_W-1:0];
    end else begin
      y_out = $signed(scaled[DATA_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x1_q <= '0;
      x2_q <= '0;
      y1_q <= '0;
      y2_q <= '0;
    end else if (step && run) begin
      x1_q <= x_in;
      x2_q <= x1;
      y1_q <= y_out;
      y2_q <= y1;
    end
  end

endmodule

// File: rtl/eq_channel.sv
module eq_channel #(
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 40,
  parameter int NUM_SECT = 2,
  parameter int IDX_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s_valid,
  input  logic signed [DATA_W-1:0] s_data,
  input  logic                     en,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [COEF_W-1:0]        cfg_data,
  output logic                     o_valid,
  output logic signed [DATA_W-1:0] o_data
);

  localparam int SC       = eq_pkg::SECT_COEFS;
  localparam int NUM_COEF = NUM_SECT * SC;

  logic [NUM_COEF-1:0][COEF_W-1:0] coefs;
  logic                            en_prev;

  // Stage s carries the sample entering section s; the last stage is the output.
  logic [NUM_SECT:0]        st_v;
  logic [NUM_SECT-1:0]      st_e;
  logic [NUM_SECT-1:0]      st_c;
  logic signed [DATA_W-1:0] st_d [NUM_SECT+1];

  eq_coef_bank #(
    .COEF_W   (COEF_W),
    .NUM_COEF (NUM_COEF),
    .IDX_W    (IDX_W),
    .LIVE_N   (SC)
  ) i_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_data),
    .commit  (s_valid),
    .view    (coefs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev <= 1'b0;
    end else if (s_valid) begin
      en_prev <= en;
    end
  end

  assign st_v[0] = s_valid;
  assign st_d[0] = s_data;
  assign st_e[0] = en;
  assign st_c[0] = en & ~en_prev;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    logic signed [DATA_W-1:0] y;
    logic                     q_v;
    logic signed [DATA_W-1:0] q_d;

    eq_section #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W)
    ) i_sect (
      .clk   (clk),
      .rst   (rst),
      .step  (st_v[s]),
      .run   (st_e[s]),
      .clear (st_c[s]),
      .x_in  (st_d[s]),
      .coef  (coefs[s*SC +: SC]),
      .y_out (y)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        q_v <= 1'b0;
        q_d <= '0;
      end else begin
        q_v <= st_v[s];
        if (st_v[s]) begin
          q_d <= st_e[s] ? y : st_d[s];
        end
      end
    end

    assign st_v[s+1] = q_v;
    assign st_d[s+1] = q_d;

    if (s + 1 < NUM_SECT) begin : g_fwd
      logic q_e, q_c;
      always_ff @(posedge clk) begin
        if (rst) begin
          q_e <= 1'b0;
          q_c <= 1'b0;
        end else if (st_v[s]) begin
          q_e <= st_e[s];
          q_c <= st_c[s];
        end
      end
      assign st_e[s+1] = q_e;
      assign st_c[s+1] = q_c;
    end
  end

  assign o_valid = st_v[NUM_SECT];
  assign o_data  = st_d[NUM_SECT];

endmodule

// File: rtl/eq_stereo.sv
module eq_stereo #(
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 40,
  parameter int NUM_SECT = 2,
  localparam int NUM_CH  = 2,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int IDX_W   = $clog2(NUM_SECT * eq_pkg::SECT_COEFS),
  localparam int ADDR_W  = IDX_W + CH_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     eq_en,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [COEF_W-1:0]        cfg_wdata,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right
);

  logic signed [DATA_W-1:0] ch_in  [NUM_CH];
  logic signed [DATA_W-1:0] ch_out [NUM_CH];
  logic [NUM_CH-1:0]        ch_v;

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_we;
    assign sel_we = cfg_we && (cfg_addr[ADDR_W-1 -: CH_W] == CH_W'(c));

    eq_channel #(
      .DATA_W   (DATA_W),
      .COEF_W   (COEF_W),
      .ACC_W    (ACC_W),
      .NUM_SECT (NUM_SECT),
      .IDX_W    (IDX_W)
    ) i_chan (
      .clk      (clk),
      .rst      (rst),
      .s_valid  (in_valid),
      .s_data   (ch_in[c]),
      .en       (eq_en),
      .cfg_we   (sel_we),
      .cfg_idx  (cfg_addr[IDX_W-1:0]),
      .cfg_data (cfg_wdata),
      .o_valid  (ch_v[c]),
      .o_data   (ch_out[c])
    );
  end

  assign out_valid = &ch_v;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

endmodule

// File: rtl/eq_stereo_chk.sv
module eq_stereo_chk #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     eq_en,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_left,
  input logic signed [DATA_W-1:0] in_right,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right
);

  // R1
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_left == '0 && out_right == '0));

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R6
  bypass_left_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(eq_en, 2)) |-> out_left == $past(in_left, 2));

  // R6
  bypass_right_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(eq_en, 2)) |-> out_right == $past(in_right, 2));

endmodule

bind eq_stereo eq_stereo_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .eq_en     (eq_en),
  .in_valid  (in_valid),
  .in_left   (in_left),
  .in_right  (in_right),
  .out_valid (out_valid),
  .out_left  (out_left),
  .out_right (out_right)
);

// File: tb/test_eq_stereo.sv
module test_eq_stereo;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              eq_en = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [15:0] in_left = '0;
  logic signed [15:0] in_right = '0;
  logic              cfg_we = 1'b0;
  logic [4:0]        cfg_addr = '0;
  logic [15:0]       cfg_wdata = '0;
  logic              out_valid;
  logic signed [15:0] out_left;
  logic signed [15:0] out_right;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  eq_stereo i_eq_stereo (
    .clk       (clk),
    .rst       (rst),
    .eq_en     (eq_en),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
  );

  // Gain vectors for the left channel with b0 = 16384 in both sections.
  typedef struct packed {
    logic              en;
    logic signed [15:0] xl;
    logic signed [15:0] xr;
    logic signed [15:0] el;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1,  16'sd1000,   16'sd500,  16'sd250},
    '{1'b1, -16'sd3,     -16'sd7,   -16'sd1},
    '{1'b1,  16'sd32767,  16'sd0,    16'sd8191},
    '{1'b1, -16'sd32768,  16'sd100, -16'sd8192},
    '{1'b1,  16'sd7,      16'sd0,    16'sd1},
    '{1'b1, -16'sd1,      16'sd0,   -16'sd1},
    '{1'b0,  16'sd1234,  -16'sd555,  16'sd1234},
    '{1'b0, -16'sd32768,  16'sd32767, -16'sd32768},
    '{1'b1,  16'sd0,      16'sd0,    16'sd0},
    '{1'b1,  16'sd2000,  -16'sd2000, 16'sd500}
  };

  // Reference model state, built from the recursion in the requirements.
  longint mc  [2][10];
  longint mx1 [2][2];
  longint mx2 [2][2];
  longint my1 [2][2];
  longint my2 [2][2];
  bit     men [2];

  function automatic longint mstep(int ch, longint x, bit en);
    longint v, acc, y;
    v = x;
    if (!en) begin
      men[ch] = 1'b0;
      return x;
    end
    if (!men[ch]) begin
      for (int s = 0; s < 2; s++) begin
        mx1[ch][s] = 0; mx2[ch][s] = 0; my1[ch][s] = 0; my2[ch][s] = 0;
      end
    end
    men[ch] = 1'b1;
    for (int s = 0; s < 2; s++) begin
      acc = mc[ch][s*5] * v + 2 * mc[ch][s*5+1] * mx1[ch][s]
          + mc[ch][s*5+2] * mx2[ch][s] + 2 * mc[ch][s*5+3] * my1[ch][s]
          + mc[ch][s*5+4] * my2[ch][s];
      y = acc >>> 15;
      if (y > 32767) y = 32767;
      if (y < -32768) y = -32768;
      mx2[ch][s] = mx1[ch][s];
      mx1[ch][s] = v;
      my2[ch][s] = my1[ch][s];
      my1[ch][s] = y;
      v = y;
    end
    return v;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int ch, input int idx, input longint val);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = {ch[0], idx[3:0]};
    cfg_wdata = val[15:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 10) mc[ch][idx] = val;
  endtask

  // One sample pair; optional coefficient write in the same cycle.
  task automatic sample(input bit en, input longint xl, input longint xr,
                        input bit wr, input int wch, input int widx, input longint wval,
                        output longint gl, output longint gr);
    @(negedge clk);
    eq_en    = en;
    in_valid = 1'b1;
    in_left  = xl[15:0];
    in_right = xr[15:0];
    cfg_we   = wr;
    cfg_addr = {wch[0], widx[3:0]};
    cfg_wdata = wval[15:0];
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we   = 1'b0;
    chk("R5 no output one cycle after input", out_valid, 0);
    @(negedge clk);
    chk("R5 output two cycles after input", out_valid, 1);
    gl = out_left;
    gr = out_right;
    @(negedge clk);
    chk("R5 single-cycle output strobe", out_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    longint gl, gr, el, er;
    longint seq [8];
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 10; i++) begin
        case (i % 5)
          0: mc[c][i] = 27618;
          1: mc[c][i] = -27033;
          2: mc[c][i] = 26461;
          3: mc[c][i] = 32130;
          default: mc[c][i] = -31505;
        endcase
      end
      men[c] = 1'b0;
    end

    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 out_left after reset", out_left, 0);
    chk("R1 out_right after reset", out_right, 0);

    // R1 R3 R4: default bass-boost set on both channels, full-scale steps.
    seq = '{16384, 0, 0, 0, -20000, 30000, 32767, -32768};
    for (int i = 0; i < 8; i++) begin
      sample(1'b1, seq[i], -seq[i] / 2, 1'b0, 0, 0, 0, gl, gr);
      el = mstep(0, seq[i], 1'b1);
      er = mstep(1, -seq[i] / 2, 1'b1);
      chk("R1 R3 R4 default left", gl, el);
      chk("R1 R3 R4 default right", gr, er);
    end

    // Left to a quarter gain: b0 = 16384 in both sections, all else zero.
    for (int i = 0; i < 10; i++) begin
      cfg_write(0, i, (i % 5 == 0) ? 16384 : 0);
    end

    // R3 R6 R9: gain and bypass vectors, right still on defaults.
    for (int i = 0; i < NVEC; i++) begin
      sample(VEC[i].en, VEC[i].xl, VEC[i].xr, 1'b0, 0, 0, 0, gl, gr);
      el = mstep(0, VEC[i].xl, VEC[i].en);
      er = mstep(1, VEC[i].xr, VEC[i].en);
      chk(VEC[i].en ? "R3 vector left" : "R6 bypass left", gl, VEC[i].el);
      chk(VEC[i].en ? "R9 vector right" : "R6 bypass right", gr, er);
      chk("R3 model agrees with vector", el, VEC[i].el);
    end

    // R2: slot 10 is dropped, gain stays a quarter.
    cfg_write(0, 10, 32767);
    sample(1'b1, 1000, 0, 1'b0, 0, 0, 0, gl, gr);
    el = mstep(0, 1000, 1'b1);
    er = mstep(1, 0, 1'b1);
    chk("R2 dropped slot left", gl, 250);
    chk("R9 right unaffected", gr, er);

    // R8: write in the same cycle as a sample applies from the next one.
    sample(1'b1, 1000, 0, 1'b1, 0, 0, 32767, gl, gr);
    er = mstep(1, 0, 1'b1);
    chk("R8 old coefficient used", gl, 250);
    mc[0][0] = 32767;
    el = mstep(0, 1000, 1'b1);
    sample(1'b1, 1000, 0, 1'b0, 0, 0, 0, gl, gr);
    er = mstep(1, 0, 1'b1);
    chk("R8 new coefficient used", gl, 499);
    chk("R8 model agrees", el, 499);

    // R4: first section would reach +32768; clamped to 32767, then -32767.
    cfg_write(0, 0, -32768);
    cfg_write(0, 5, -32768);
    sample(1'b1, -32768, 0, 1'b0, 0, 0, 0, gl, gr);
    el = mstep(0, -32768, 1'b1);
    er = mstep(1, 0, 1'b1);
    chk("R4 clamp between sections", gl, -32767);
    chk("R9 right unaffected by left writes", gr, er);

    // R7: build right history, bypass one sample, re-enable with cleared state.
    seq = '{20000, -15000, 8000, 0, 0, 0, 0, 0};
    for (int i = 0; i < 3; i++) begin
      sample(1'b1, 0, seq[i], 1'b0, 0, 0, 0, gl, gr);
      el = mstep(0, 0, 1'b1);
      er = mstep(1, seq[i], 1'b1);
      chk("R3 history build right", gr, er);
    end
    sample(1'b0, -77, 500, 1'b0, 0, 0, 0, gl, gr);
    el = mstep(0, -77, 1'b0);
    er = mstep(1, 500, 1'b0);
    chk("R6 bypass left", gl, -77);
    chk("R6 bypass right", gr, 500);
    sample(1'b1, 0, 1000, 1'b0, 0, 0, 0, gl, gr);
    el = mstep(0, 0, 1'b1);
    er = mstep(1, 1000, 1'b1);
    chk("R7 cleared history right", gr, er);
    chk("R7 cleared history left", gl, el);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule